// File: doc/BRIEF.md
# Ring Interrupt Sender ID Queue

This block sits on the receive side of a node attached to a unidirectional ring. Every word that arrives from the ring is tagged with the ID of the node that launched it. Some words are interrupt words aimed at one of three interrupt levels. For each interrupt word, the block stores the sender ID in a small first-in first-out queue that belongs to that level. While a level is armed and its queue holds at least one ID, the block raises that level's interrupt request.

The CPU services an interrupt through a simple register bus. Each level has its own ID register. Reading the register returns the oldest queued sender ID, removes it from the queue and re-arms the level. The request drops for one cycle and then comes back if more IDs are waiting. Writing the register discards everything queued for that level. This lets software flush a level whose interrupt was masked before it enables the level again. Each level has a sticky overflow flag that records interrupt words lost because the queue was full.

Top module: `ring_irq_srcid_queue`

## Requirements
- R1: When `rx_valid` and `rx_is_irq` are both high and `rx_level` is 0, 1 or 2, the sender ID is appended to that level's queue. A word with `rx_is_irq` low, or with level code 3, changes no queue, flag or request.
- R2: After reset, every level is armed and empty, `irq` and `ovf` are all zero, and `bus_rdata` is 0x00. `irq[l]` is high exactly when level l is armed and its queue is not empty.
- R3: A read (`bus_en`=1, `bus_we`=0) at address 0x26 + 4*l (0x26 for level 0, 0x2A for level 1, 0x2E for level 2) of a non-empty level removes the oldest entry. From the following cycle, `bus_rdata` holds that entry, so IDs come out in arrival order.
- R4: After a read that removes an entry, `irq[l]` is low for the next cycle. One cycle later it is high again if entries remain.
- R5: A read of an empty level, or of an address that maps to no level, sets `bus_rdata` to 0xFF and changes no queue, flag or request.
- R6: A write (`bus_en`=1, `bus_we`=1) to a level's address empties that level's queue, clears its `ovf` bit and arms it. A write to an address that maps to no level has no effect.
- R7: Each queue holds 8 IDs. An interrupt word that arrives when the queue is full, with no read of that level in the same cycle, is dropped and sets `ovf[l]`. `ovf[l]` then stays set until the next write to that level.
- R8: An interrupt word and a removing read for the same level in the same cycle both take effect. If the queue is full, the word is still stored, because the read frees a slot, and `ovf` does not change.
- R9: A write to a level and an interrupt word for the same level in the same cycle leave the queue empty. The arriving ID is discarded and does not set `ovf`.
- R10: Two back-to-back reads of the same level remove two entries. The second read returns the next ID, and the request stays low across both reads.
- R11: The three levels are independent. Traffic, reads and writes on one level leave the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received ring word is present this cycle |
| rx_is_irq | input | 1 | 1 = interrupt word, 0 = data word |
| rx_level | input | 2 | Target interrupt level of the word (0..2; 3 is not a level) |
| rx_sender | input | 8 | ID of the node that launched the word |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write (flush), 0 = read (pop) |
| bus_addr | input | 8 | Byte address of the access |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| irq | output | 3 | Interrupt request per level |
| ovf | output | 3 | Sticky lost-interrupt flag per level |

## Verification
Two pairs of functions can collide in one cycle on the same level. One pair is an arriving interrupt word and a removing read: the bench provokes it on a full queue and judges it by the overflow flag staying clear and by the drained order ending with the arriving ID. The other pair is an arriving interrupt word and a flushing write: the bench judges it by the queue staying empty, the request staying low and the overflow flag staying clear. Back-to-back reads are also driven, to show that an extra read consumes an entry that never raised its own request.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int unsigned RSQ_ID_W   = 8;
  localparam int unsigned RSQ_DEPTH  = 8;
  localparam int unsigned RSQ_LVLS   = 3;
  localparam int unsigned RSQ_ADDR_W = 8;
  localparam int unsigned RSQ_BASE   = 'h26;
  localparam int unsigned RSQ_STRIDE = 4;

  // Byte address of the ID register for one interrupt level.
  function automatic int unsigned rsq_lvl_addr(input int unsigned base,
                                               input int unsigned stride,
                                               input int unsigned lvl);
    return base + stride * lvl;
  endfunction

endpackage

// File: rtl/rsq_bus_dec.sv
module rsq_bus_dec
  import rsq_pkg::*;
#(
  parameter int unsigned LVLS   = RSQ_LVLS,
  parameter int unsigned ADDR_W = RSQ_ADDR_W,
  parameter int unsigned BASE   = RSQ_BASE,
  parameter int unsigned STRIDE = RSQ_STRIDE
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              rd_req,
  output logic [LVLS-1:0]   rd_hit,
  output logic [LVLS-1:0]   wr_hit
);

  assign rd_req = bus_en & ~bus_we;

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    logic match;
    assign match     = (bus_addr == ADDR_W'(rsq_lvl_addr(BASE, STRIDE, g)));
    assign rd_hit[g] = bus_en & ~bus_we & match;
    assign wr_hit[g] = bus_en &  bus_we & match;
  end

endmodule

// File: rtl/rsq_rx_demux.sv
module rsq_rx_demux
  import rsq_pkg::*;
#(
  parameter int unsigned LVLS  = RSQ_LVLS,
  localparam int unsigned LVL_W = (LVLS > 1) ? $clog2(LVLS) : 1
) (
  input  logic             rx_valid,
  input  logic             rx_is_irq,
  input  logic [LVL_W-1:0] rx_level,
  output logic [LVLS-1:0]  push
);

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    assign push[g] = rx_valid & rx_is_irq & (rx_level == LVL_W'(g));
  end

endmodule

// File: rtl/rsq_id_fifo.sv
module rsq_id_fifo
  import rsq_pkg::*;
#(
  parameter int unsigned ID_W  = RSQ_ID_W,
  parameter int unsigned DEPTH = RSQ_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ID_W-1:0]  din,
  input  logic             pop,
  input  logic             flush,
  output logic [ID_W-1:0]  head,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             pop_done
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ID_W-1:0]  mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             empty, has_room, push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Next state: a flush wins over everything; a pop in the same cycle
  // frees the slot a push into a full queue needs.
  always_comb begin
    empty    = (cnt_q == '0);
    pop_ok   = pop & ~flush & ~empty;
    has_room = (cnt_q != CNT_W'(DEPTH)) | pop_ok;
    push_ok  = push & ~flush & has_room;

    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (push_ok) wr_d = ptr_inc(wr_q);
      if (pop_ok)  rd_d = ptr_inc(rd_q);
      cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (push && !has_room) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // Storage carries no reset; the head is only used when cnt is non-zero.
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= din;
  end

  assign head     = mem_q[rd_q];
  assign cnt      = cnt_q;
  assign ovf      = ovf_q;
  assign pop_done = pop_ok;

endmodule

// File: rtl/rsq_arm_ctrl.sv
module rsq_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pop_done,
  input  logic flush,
  output logic armed
);

  logic armed_q, armed_d;

  // Disarmed for the single cycle after an entry is taken; a flush re-arms.
  always_comb begin
    armed_d = armed_q;
    if (flush)         armed_d = 1'b1;
    else if (pop_done) armed_d = 1'b0;
    else               armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end

  assign armed = armed_q;

endmodule

// File: rtl/ring_irq_srcid_queue.sv
module ring_irq_srcid_queue
  import rsq_pkg::*;
#(
  parameter int unsigned ID_W   = RSQ_ID_W,
  parameter int unsigned DEPTH  = RSQ_DEPTH,
  parameter int unsigned LVLS   = RSQ_LVLS,
  parameter int unsigned ADDR_W = RSQ_ADDR_W,
  parameter int unsigned BASE   = RSQ_BASE,
  parameter int unsigned STRIDE = RSQ_STRIDE,
  localparam int unsigned LVL_W = (LVLS > 1) ? $clog2(LVLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_is_irq,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [ID_W-1:0]   rx_sender,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [ID_W-1:0]   bus_rdata,
  output logic [LVLS-1:0]   irq,
  output logic [LVLS-1:0]   ovf
);

  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic                   rd_req;
  logic [LVLS-1:0]        rd_hit, wr_hit, push, pop_done, armed, lvl_empty;
  logic [ID_W-1:0]        head_arr [LVLS];
  logic [LVLS*CNT_W-1:0]  cnt_flat;
  logic [ID_W-1:0]        sel_head, rdata_q, rdata_d;

  rsq_bus_dec #(
    .LVLS(LVLS), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
  ) u_dec (
    .bus_en  (bus_en),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .rd_req  (rd_req),
    .rd_hit  (rd_hit),
    .wr_hit  (wr_hit)
  );

  rsq_rx_demux #(.LVLS(LVLS)) u_demux (
    .rx_valid (rx_valid),
    .rx_is_irq(rx_is_irq),
    .rx_level (rx_level),
    .push     (push)
  );

  for (genvar g = 0; g < LVLS; g++) begin : g_lvl
    logic [CNT_W-1:0] cnt_g;

    rsq_id_fifo #(.ID_W(ID_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push[g]),
      .din     (rx_sender),
      .pop     (rd_hit[g]),
      .flush   (wr_hit[g]),
      .head    (head_arr[g]),
      .cnt     (cnt_g),
      .ovf     (ovf[g]),
      .pop_done(pop_done[g])
    );

    rsq_arm_ctrl u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .pop_done(pop_done[g]),
      .flush   (wr_hit[g]),
      .armed   (armed[g])
    );

    assign lvl_empty[g]                = (cnt_g == '0);
    assign cnt_flat[g*CNT_W +: CNT_W]  = cnt_g;
    assign irq[g]                      = armed[g] & ~lvl_empty[g];
  end

  // Read data: head of the addressed non-empty level, else the empty code.
  always_comb begin
    sel_head = '1;
    for (int l = 0; l < LVLS; l++) begin
      if (rd_hit[l] && !lvl_empty[l]) sel_head = head_arr[l];
    end
    rdata_d = rdata_q;
    if (rd_req) rdata_d = sel_head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker
  import rsq_pkg::*;
#(
  parameter int unsigned ID_W   = RSQ_ID_W,
  parameter int unsigned DEPTH  = RSQ_DEPTH,
  parameter int unsigned LVLS   = RSQ_LVLS,
  parameter int unsigned ADDR_W = RSQ_ADDR_W,
  parameter int unsigned BASE   = RSQ_BASE,
  parameter int unsigned STRIDE = RSQ_STRIDE,
  localparam int unsigned LVL_W = (LVLS > 1) ? $clog2(LVLS) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rx_valid,
  input logic                  rx_is_irq,
  input logic [LVL_W-1:0]      rx_level,
  input logic                  bus_en,
  input logic                  bus_we,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [ID_W-1:0]       bus_rdata,
  input logic [LVLS-1:0]       irq,
  input logic [LVLS-1:0]       ovf,
  input logic [LVLS*CNT_W-1:0] cnt_flat
);

  logic inert_word;
  assign inert_word = rx_valid && (!rx_is_irq || (32'(rx_level) >= LVLS));

  // R1: non-interrupt words and unused level codes leave all queues alone
  assert_inert_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inert_word && !bus_en |=> $stable(cnt_flat));

  for (genvar g = 0; g < LVLS; g++) begin : g_chk
    logic             sel;
    logic [CNT_W-1:0] cnt_g;
    assign sel   = (bus_addr == ADDR_W'(rsq_lvl_addr(BASE, STRIDE, g)));
    assign cnt_g = cnt_flat[g*CNT_W +: CNT_W];

    assert_irq_backed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> cnt_g != '0);

    assert_pop_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_en && !bus_we && sel && cnt_g != '0 |=> !irq[g]);

    assert_empty_read_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_en && !bus_we && sel && cnt_g == '0 |=> bus_rdata == '1);

    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_en && bus_we && sel |=> cnt_g == '0 && !ovf[g]);

    assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_g <= CNT_W'(DEPTH));

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf[g] && !(bus_en && bus_we && sel) |=> ovf[g]);
  end

endmodule

bind ring_irq_srcid_queue rsq_checker #(
  .ID_W(ID_W), .DEPTH(DEPTH), .LVLS(LVLS),
  .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_valid (rx_valid),
  .rx_is_irq(rx_is_irq),
  .rx_level (rx_level),
  .bus_en   (bus_en),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .ovf      (ovf),
  .cnt_flat (cnt_flat)
);

// File: tb/sim_ring_irq_srcid_queue.sv
module sim_ring_irq_srcid_queue;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_is_irq;
  logic [1:0] rx_level;
  logic [7:0] rx_sender;
  logic       bus_en, bus_we;
  logic [7:0] bus_addr;
  logic [7:0] rdata;
  logic [2:0] irq, ovf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Reference model state
  logic [7:0] mq [3][$];
  bit         m_armed [3];
  bit         m_ovf   [3];
  logic [7:0] m_rdata;

  always #10 clk = ~clk;

  ring_irq_srcid_queue u0 (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_is_irq(rx_is_irq), .rx_level(rx_level), .rx_sender(rx_sender),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_rdata(rdata), .irq(irq), .ovf(ovf)
  );

  function automatic int lvl_of(input logic [7:0] a);
    case (a)
      8'h26:   return 0;
      8'h2A:   return 1;
      8'h2E:   return 2;
      default: return -1;
    endcase
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [7:0] ei, eo;
    ei = '0; eo = '0;
    for (int l = 0; l < 3; l++) begin
      ei[l] = m_armed[l] && (mq[l].size() > 0);
      eo[l] = m_ovf[l];
    end
    cmp(tag, "irq", {5'b0, irq}, ei);
    cmp(tag, "ovf", {5'b0, ovf}, eo);
    cmp(tag, "rdata", rdata, m_rdata);
  endtask

  // One clock: drive at the falling edge, update the model after the rising
  // edge, compare at the next falling edge.
  task automatic step(input bit en, input bit we, input logic [7:0] addr,
                      input bit rv, input bit ri, input logic [1:0] rl,
                      input logic [7:0] rid, input string tag);
    int  rd_l, fl_l, pu_l;
    bit  popped;
    bus_en = en; bus_we = we; bus_addr = addr;
    rx_valid = rv; rx_is_irq = ri; rx_level = rl; rx_sender = rid;
    @(posedge clk);
    rd_l = (en && !we) ? lvl_of(addr) : -1;
    fl_l = (en && we)  ? lvl_of(addr) : -1;
    pu_l = (rv && ri && rl < 3) ? int'(rl) : -1;
    popped = (rd_l >= 0) && (mq[rd_l].size() > 0);
    if (en && !we) m_rdata = popped ? mq[rd_l][0] : 8'hFF;
    for (int l = 0; l < 3; l++) m_armed[l] = (fl_l == l) ? 1'b1 : !(popped && rd_l == l);
    if (popped) void'(mq[rd_l].pop_front());
    if (fl_l >= 0) begin
      mq[fl_l].delete();
      m_ovf[fl_l] = 1'b0;
    end
    if (pu_l >= 0 && pu_l != fl_l) begin
      if (mq[pu_l].size() < 8) mq[pu_l].push_back(rid);
      else m_ovf[pu_l] = 1'b1;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 8'h00, 0, 0, 2'd0, 8'h00, tag);
  endtask
  task automatic rx(input logic [1:0] l, input logic [7:0] id, input string tag);
    step(0, 0, 8'h00, 1, 1, l, id, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    step(1, 0, a, 0, 0, 2'd0, 8'h00, tag);
  endtask
  task automatic wr(input logic [7:0] a, input string tag);
    step(1, 1, a, 0, 0, 2'd0, 8'h00, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    bus_en = 0; bus_we = 0; bus_addr = '0;
    rx_valid = 0; rx_is_irq = 0; rx_level = '0; rx_sender = '0;
    for (int l = 0; l < 3; l++) begin
      m_armed[l] = 1'b1;
      m_ovf[l]   = 1'b0;
    end
    m_rdata = 8'h00;
    repeat (3) @(negedge clk);
    // R2: reset state
    cmp("R2", "irq at reset", {5'b0, irq}, 8'h00);
    cmp("R2", "ovf at reset", {5'b0, ovf}, 8'h00);
    cmp("R2", "rdata at reset", rdata, 8'h00);
    rst_n = 1'b1;
    idle("R2");

    // R1: data words and the unused level code are ignored
    step(0, 0, 8'h00, 1, 0, 2'd0, 8'hA1, "R1");
    step(0, 0, 8'h00, 1, 0, 2'd2, 8'hA2, "R1");
    step(0, 0, 8'h00, 1, 1, 2'd3, 8'hA3, "R1");
    cmp("R1", "irq after inert words", {5'b0, irq}, 8'h00);
    rd(8'h26, "R1");
    cmp("R1", "level 0 still empty", rdata, 8'hFF);

    // R1/R3/R4: queue three IDs on level 0, pop one
    rx(2'd0, 8'h11, "R1");
    rx(2'd0, 8'h12, "R1");
    rx(2'd0, 8'h13, "R1");
    cmp("R2", "irq0 raised", {5'b0, irq}, 8'h01);
    rd(8'h26, "R3");
    cmp("R3", "oldest ID first", rdata, 8'h11);
    cmp("R4", "irq0 low after pop", {5'b0, irq}, 8'h00);
    idle("R4");
    cmp("R4", "irq0 back", {5'b0, irq}, 8'h01);

    // R10: two reads in one interrupt cycle consume two entries
    rd(8'h26, "R10");
    cmp("R10", "first read", rdata, 8'h12);
    rd(8'h26, "R10");
    cmp("R10", "second read skips ahead", rdata, 8'h13);
    cmp("R10", "irq0 stays low", {5'b0, irq}, 8'h00);
    idle("R10");
    cmp("R10", "queue drained early", {5'b0, irq}, 8'h00);

    // R5: empty and unmapped reads
    rx(2'd1, 8'h21, "R11");
    rd(8'h26, "R5");
    cmp("R5", "empty read code", rdata, 8'hFF);
    rd(8'h27, "R5");
    cmp("R5", "unmapped read code", rdata, 8'hFF);
    rd(8'h30, "R5");
    cmp("R5", "level 1 untouched", {5'b0, irq}, 8'h02);

    // R11: levels independent
    rx(2'd2, 8'h31, "R11");
    rx(2'd1, 8'h22, "R11");
    rx(2'd2, 8'h32, "R11");
    rd(8'h2E, "R11");
    cmp("R11", "level 2 head", rdata, 8'h31);
    rd(8'h2A, "R11");
    cmp("R11", "level 1 head", rdata, 8'h21);
    idle("R11");
    cmp("R11", "both levels pending", {5'b0, irq}, 8'h06);

    // R6: flush by write; unmapped write ignored
    wr(8'h2E, "R6");
    cmp("R6", "level 2 flushed", {5'b0, irq}, 8'h02);
    wr(8'h20, "R6");
    rd(8'h2A, "R6");
    cmp("R6", "level 1 survives unmapped write", rdata, 8'h22);
    rd(8'h2E, "R6");
    cmp("R6", "flushed level empty", rdata, 8'hFF);

    // R7: overflow on level 1
    for (int i = 0; i < 9; i++) rx(2'd1, 8'h50 + 8'(i), "R7");
    cmp("R7", "ovf1 set", {5'b0, ovf}, 8'h02);
    for (int i = 0; i < 8; i++) begin
      rd(8'h2A, "R7");
      cmp("R7", "drain order", rdata, 8'h50 + 8'(i));
      idle("R7");
    end
    rd(8'h2A, "R7");
    cmp("R7", "dropped ID absent", rdata, 8'hFF);
    cmp("R7", "ovf1 sticky", {5'b0, ovf}, 8'h02);
    wr(8'h2A, "R6");
    cmp("R6", "flush clears ovf1", {5'b0, ovf}, 8'h00);

    // R8: push and pop on a full queue in the same cycle
    for (int i = 0; i < 8; i++) rx(2'd2, 8'h40 + 8'(i), "R8");
    step(1, 0, 8'h2E, 1, 1, 2'd2, 8'h48, "R8");
    cmp("R8", "pop during push", rdata, 8'h40);
    cmp("R8", "no overflow", {5'b0, ovf}, 8'h00);
    for (int i = 1; i < 9; i++) begin
      rd(8'h2E, "R8");
      cmp("R8", "drain incl. arriving ID", rdata, 8'h40 + 8'(i));
    end

    // R9: flush and arriving word on the same level
    rx(2'd1, 8'h61, "R9");
    step(1, 1, 8'h2A, 1, 1, 2'd1, 8'h62, "R9");
    cmp("R9", "queue empty", {5'b0, irq}, 8'h00);
    cmp("R9", "no ovf", {5'b0, ovf}, 8'h00);
    rd(8'h2A, "R9");
    cmp("R9", "arriving ID discarded", rdata, 8'hFF);
    idle("R9");

    finish_run();
  end

endmodule